// File: doc/BRIEF.md
# I2C Master with Address Polling

This block is a single-master I2C controller that a host steers one command at a time. There are four commands: open a transfer with a 7-bit target address and a direction, send a byte, receive a byte, and close the bus. The block drives SCL and SDA through open-drain enables, where a high enable pulls the line low. It samples SDA through an input.

A target that is busy may refuse its address. An EEPROM in the middle of an internal write cycle is a typical case. When the address is refused, the controller repeats the START and address phase by itself until the target accepts, or until a programmable timeout measured in SCL periods runs out.

Failures raise sticky error flags and put a STOP on the bus. A byte command can close the bus with a STOP once its byte is done. If it does not, the controller holds SCL low so that a repeated START can follow.

Top module: `i2c_poll_master`

## Requirements
- R1: One SCL period lasts 16 + 2·cfg_div·4^cfg_presc clock cycles, with equal low and high halves of 8 + cfg_div·4^cfg_presc cycles.
- R2: The address byte is sent MSB first as {cmd_addr, cmd_rd}: bit 0 is 0 for a write and 1 for a read. The start command is cmd_op = 0, a byte write is 1, a byte read is 2, and a stop is 3.
- R3: When the address byte is NACKed, the controller issues a repeated START and sends the address again, until an ACK arrives. The retries stay within the timeout of R4.
- R4: A retry is abandoned when the number of SCL periods elapsed since the start command exceeds cfg_timeout. The controller then sets err_tmo and generates a STOP. A cfg_timeout of 0 makes the first NACK final.
- R5: If SDA reads low while the controller releases it for an address bit, the controller sets err_bus, does not set err_tmo, generates a STOP and leaves the bus released.
- R6: On a read, the controller ACKs each received byte unless cmd_last is set, in which case it NACKs. The received byte appears on rdata MSB first.
- R7: On a write, a data byte that is not ACKed sets err_dnack and generates a STOP, whatever cmd_last and cmd_stop say.
- R8: After a successful byte, a STOP follows when both cmd_last and cmd_stop are set. Otherwise SCL stays pulled low (scl_oe = 1) and no STOP is sent.
- R9: SDA changes only while SCL is low, except that START is SDA falling with SCL high and STOP is SDA rising with SCL high. Each transfer therefore shows exactly the expected START and STOP events.
- R10: err_tmo, err_bus and err_dnack stay set until err_clr is pulsed. A flag set in the same cycle as err_clr wins over the clear.
- R11: busy goes high in the cycle after a command is accepted (cmd_valid with busy low) and falls when the operation ends. A command presented while busy is ignored.
- R12: After reset, busy and all error flags are 0 and both line enables are 0, which releases the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_div | input | DIV_W | SCL divider value |
| cfg_presc | input | 2 | SCL prescaler exponent (factor 4^n) |
| cfg_timeout | input | TMO_W | Address retry limit in SCL periods; 0 disables retrying |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command: 0 start, 1 write byte, 2 read byte, 3 stop |
| cmd_addr | input | 7 | Target address for a start command |
| cmd_rd | input | 1 | Direction for a start command: 1 read, 0 write |
| cmd_wdata | input | 8 | Byte to send on a write command |
| cmd_last | input | 1 | Byte is the last of the transfer |
| cmd_stop | input | 1 | Send STOP after the last byte |
| busy | output | 1 | Command in progress |
| rdata | output | 8 | Last received byte |
| err_clr | input | 1 | Clears all error flags |
| err_tmo | output | 1 | Sticky: address retries timed out |
| err_bus | output | 1 | Sticky: unexpected SDA level during the address phase |
| err_dnack | output | 1 | Sticky: a written data byte was not ACKed |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | SDA line level |

## Verification
busy rises exactly one cycle after acceptance and is checked at the next falling clock edge. Every other result is due only once busy falls: rdata, the error flags, the target's received bytes and the START and STOP counts. A byte takes 18 half periods, and a START takes two or three more. The bench therefore waits for busy to drop and samples 1 ns after a falling edge, which leaves room for the bus model's own falling-edge updates. The SCL period is measured as the number of clock cycles between consecutive SCL rising edges inside a byte, and is compared with the value computed from the divider settings.

// File: rtl/i2c_poll_master.sv
module i2c_poll_master #(
  parameter int DIV_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_presc,
  input  logic [TMO_W-1:0] cfg_timeout,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [6:0]       cmd_addr,
  input  logic             cmd_rd,
  input  logic [7:0]       cmd_wdata,
  input  logic             cmd_last,
  input  logic             cmd_stop,
  output logic             busy,
  output logic [7:0]       rdata,
  input  logic             err_clr,
  output logic             err_tmo,
  output logic             err_bus,
  output logic             err_dnack,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_i
);
  localparam int HW = DIV_W + 7;
  localparam logic [1:0] OP_START = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;
  localparam logic [1:0] K_ADDR = 2'd0, K_WR = 2'd1, K_RD = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;

  st_t              st;
  logic [1:0]       ph, kind;
  logic [3:0]       bitn;
  logic [HW-1:0]    cnt, hh;
  logic [HW:0]      pcnt;
  logic [TMO_W-1:0] elap;
  logic [7:0]       shreg;
  logic             held, last, stopq, berr;
  logic             mid, pend, txbit, drive, ack, give_up;

  assign hh      = HW'(8) + (HW'(cfg_div) << {cfg_presc, 1'b0});
  assign mid     = cnt == (hh >> 1);
  assign pend    = cnt == hh - HW'(1);
  assign txbit   = shreg[3'd7 - bitn[2:0]];
  assign drive   = (bitn == 4'd8) ? (kind == K_RD && !last) : (kind != K_RD && !txbit);
  assign ack     = !sda_i;
  assign give_up = (cfg_timeout == '0) || (elap > cfg_timeout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (st == S_IDLE || pend) cnt <= '0;
    else                           cnt <= cnt + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      elap <= '0;
    end else if (st == S_IDLE && cmd_valid && cmd_op == OP_START) begin
      pcnt <= '0;
      elap <= '0;
    end else if (busy) begin
      if (pcnt == {hh, 1'b0} - (HW+1)'(1)) begin
        pcnt <= '0;
        if (elap != '1) elap <= elap + TMO_W'(1);
      end else begin
        pcnt <= pcnt + (HW+1)'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= '0;
      kind      <= K_ADDR;
      bitn      <= '0;
      shreg     <= '0;
      rdata     <= '0;
      held      <= 1'b0;
      last      <= 1'b0;
      stopq     <= 1'b0;
      berr      <= 1'b0;
      busy      <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      err_tmo   <= 1'b0;
      err_bus   <= 1'b0;
      err_dnack <= 1'b0;
    end else begin
      if (err_clr) begin
        err_tmo   <= 1'b0;
        err_bus   <= 1'b0;
        err_dnack <= 1'b0;
      end
      case (st)
        S_IDLE: if (cmd_valid) begin
          busy <= 1'b1;
          case (cmd_op)
            OP_START: begin
              shreg <= {cmd_addr, cmd_rd};
              kind  <= K_ADDR;
              st    <= S_START;
              ph    <= held ? 2'd0 : 2'd1;
            end
            OP_WR, OP_RD: begin
              shreg  <= cmd_wdata;
              kind   <= (cmd_op == OP_WR) ? K_WR : K_RD;
              last   <= cmd_last;
              stopq  <= cmd_stop;
              bitn   <= '0;
              ph     <= 2'd0;
              st     <= S_BIT;
              scl_oe <= 1'b1;
            end
            default: begin
              st     <= S_STOP;
              ph     <= 2'd0;
              scl_oe <= 1'b1;
            end
          endcase
        end

        S_START: case (ph)
          2'd0: begin
            if (mid) sda_oe <= 1'b0;
            if (pend) begin scl_oe <= 1'b0; ph <= 2'd1; end
          end
          2'd1: if (pend) begin sda_oe <= 1'b1; ph <= 2'd2; end
          default: if (pend) begin
            scl_oe <= 1'b1;
            st     <= S_BIT;
            bitn   <= '0;
            ph     <= 2'd0;
            berr   <= 1'b0;
          end
        endcase

        S_BIT: if (ph == 2'd0) begin
          if (mid) sda_oe <= drive;
          if (pend) begin scl_oe <= 1'b0; ph <= 2'd1; end
        end else if (pend) begin
          scl_oe <= 1'b1;
          ph     <= 2'd0;
          if (bitn != 4'd8) begin
            if (kind == K_RD) shreg <= {shreg[6:0], sda_i};
            if (kind == K_ADDR && txbit && !sda_i) berr <= 1'b1;
            bitn <= bitn + 4'd1;
          end else begin
            case (kind)
              K_ADDR:
                if (berr) begin
                  err_bus <= 1'b1;
                  st      <= S_STOP;
                end else if (ack) begin
                  st <= S_IDLE; held <= 1'b1; busy <= 1'b0;
                end else if (give_up) begin
                  err_tmo <= 1'b1;
                  st      <= S_STOP;
                end else begin
                  st <= S_START;
                end
              K_WR:
                if (!ack) begin
                  err_dnack <= 1'b1;
                  st        <= S_STOP;
                end else if (last && stopq) begin
                  st <= S_STOP;
                end else begin
                  st <= S_IDLE; held <= 1'b1; busy <= 1'b0;
                end
              default: begin
                rdata <= shreg;
                if (last && stopq) st <= S_STOP;
                else begin st <= S_IDLE; held <= 1'b1; busy <= 1'b0; end
              end
            endcase
          end
        end

        default: case (ph)
          2'd0: begin
            if (mid) sda_oe <= 1'b1;
            if (pend) begin scl_oe <= 1'b0; ph <= 2'd1; end
          end
          2'd1: if (pend) begin sda_oe <= 1'b0; ph <= 2'd2; end
          default: if (pend) begin
            st   <= S_IDLE;
            held <= 1'b0;
            busy <= 1'b0;
          end
        endcase
      endcase
    end
  end
endmodule

module i2c_poll_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       busy,
  input logic       held,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       err_clr,
  input logic       err_tmo,
  input logic       err_bus,
  input logic       err_dnack,
  input logic [1:0] st
);
  localparam logic [1:0] ST_START = 2'd1, ST_STOP = 2'd3;

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy);

  p_start_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> (st == ST_START));

  p_stop_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> (st == ST_STOP));

  p_tmo_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_tmo) && !$past(err_clr)) |-> err_tmo);

  p_bus_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_bus) && !$past(err_clr)) |-> err_bus);

  p_dnack_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_dnack) && !$past(err_clr)) |-> err_dnack);

  p_idle_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !held) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_poll_master i2c_poll_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .held(held),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .err_clr(err_clr), .err_tmo(err_tmo),
  .err_bus(err_bus), .err_dnack(err_dnack), .st(st)
);

// File: tb/sim_i2c_poll_master.sv
module sim_i2c_poll_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  cfg_div = 8'd2;
  logic [1:0]  cfg_presc = 2'd0;
  logic [15:0] cfg_timeout = 16'd50;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [6:0]  cmd_addr = 7'd0;
  logic        cmd_rd = 1'b0, cmd_last = 1'b0, cmd_stop = 1'b0, err_clr = 1'b0;
  logic [7:0]  cmd_wdata = 8'd0;
  logic        busy, err_tmo, err_bus, err_dnack, scl_oe, sda_oe;
  logic [7:0]  rdata;
  logic        tpull = 1'b0, jam = 1'b0;
  logic        scl_line, sda_line;

  assign scl_line = !scl_oe;
  assign sda_line = !sda_oe && !tpull && !jam;

  i2c_poll_master u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_presc(cfg_presc),
    .cfg_timeout(cfg_timeout), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata),
    .cmd_last(cmd_last), .cmd_stop(cmd_stop), .busy(busy), .rdata(rdata),
    .err_clr(err_clr), .err_tmo(err_tmo), .err_bus(err_bus),
    .err_dnack(err_dnack), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [7:0] tx_data(int i);
    return 8'(i * 37 + 90);
  endfunction

  function automatic int exp_period(int dv, int pr);
    return 16 + 2 * dv * (1 << (2 * pr));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // target model
  int starts = 0, stops = 0, bitc = 0, mode = 0, amode = 0;
  int nack_left = 0, rd_idx = 0, mack_cnt = 0, mnack_cnt = 0, wr_cnt = 0;
  int cyc = 0, last_rise = 0, meas_per = 0;
  bit wnack = 1'b0, mack_bit = 1'b0, ps = 1'b1, pd = 1'b1;
  logic [7:0] rx = 8'd0, txb = 8'd0, last_addr = 8'd0, last_wr = 8'd0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      ps = 1'b1; pd = 1'b1; bitc = 0; mode = 0; tpull = 1'b0;
    end else begin
      if (ps && scl_line && pd && !sda_line) begin
        starts++; bitc = 0; mode = 3; tpull = 1'b0;
      end else if (ps && scl_line && !pd && sda_line) begin
        stops++; mode = 0; tpull = 1'b0;
      end else if (!ps && scl_line) begin
        if (bitc > 0 && bitc < 9) meas_per = cyc - last_rise;
        last_rise = cyc;
        if (bitc < 8) begin
          rx = {rx[6:0], sda_line}; bitc++;
        end else if (bitc == 8) begin
          bitc = 9;
          if (mode == 2) begin
            mack_bit = !sda_line;
            if (mack_bit) mack_cnt++; else mnack_cnt++;
          end
        end
      end else if (ps && !scl_line) begin
        if (bitc == 8) begin
          if (mode == 3) begin
            last_addr = rx;
            if (nack_left > 0) begin nack_left--; tpull = 1'b0; amode = 0; end
            else begin tpull = 1'b1; amode = rx[0] ? 2 : 1; end
          end else if (mode == 1) begin
            last_wr = rx; wr_cnt++; tpull = !wnack;
          end else tpull = 1'b0;
        end else if (bitc == 9) begin
          bitc = 0;
          if (mode == 3) mode = amode;
          else if (mode == 2 && !mack_bit) mode = 0;
          if (mode == 2) begin
            txb = tx_data(rd_idx); rd_idx++; tpull = !txb[7];
          end else tpull = 1'b0;
        end else if (mode == 2 && bitc >= 1 && bitc <= 7) begin
          tpull = !txb[7 - bitc];
        end
      end
      ps = scl_line; pd = sda_line;
    end
  end

  task automatic run(input logic [1:0] op, input logic [6:0] a, input logic r,
                     input logic [7:0] d, input logic l, input logic s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_rd = r;
    cmd_wdata = d; cmd_last = l; cmd_stop = s;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    #1;
  endtask

  task automatic clear_errs();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0, p0, e0, m0, n0, w0;
    logic [6:0] ra;
    logic [7:0] rb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!busy && !scl_oe && !sda_oe, "R12 reset bus", {busy, scl_oe, sda_oe}, 0);
    chk(!err_tmo && !err_bus && !err_dnack, "R12 reset flags", {err_tmo, err_bus, err_dnack}, 0);

    // write transfer
    s0 = starts; p0 = stops;
    run(2'd0, 7'h50, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(last_addr == 8'hA0, "R2 write address byte", last_addr, 8'hA0);
    chk(starts - s0 == 1, "R2 one START", starts - s0, 1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_wdata = 8'h3C; cmd_last = 1'b0; cmd_stop = 1'b0;
    @(negedge clk);
    chk(busy, "R11 busy after accept", busy, 1);
    cmd_op = 2'd3;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    #1;
    chk(stops == p0, "R11 stop while busy ignored", stops - p0, 0);
    chk(last_wr == 8'h3C, "R8 write byte", last_wr, 8'h3C);
    chk(scl_oe, "R8 SCL held low", scl_oe, 1);
    chk(meas_per == exp_period(2, 0), "R1 SCL period", meas_per, exp_period(2, 0));
    run(2'd1, 7'h0, 1'b0, 8'hA5, 1'b1, 1'b1);
    chk(last_wr == 8'hA5, "R8 last byte", last_wr, 8'hA5);
    chk(stops - p0 == 1, "R8 STOP after last", stops - p0, 1);
    chk(!scl_oe && !sda_oe, "R8 bus released", {scl_oe, sda_oe}, 0);

    // read transfer
    s0 = starts; p0 = stops; e0 = rd_idx; m0 = mack_cnt; n0 = mnack_cnt;
    run(2'd0, 7'h51, 1'b1, 8'h00, 1'b0, 1'b0);
    chk(last_addr == 8'hA3, "R2 read address byte", last_addr, 8'hA3);
    run(2'd2, 7'h0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(rdata == tx_data(e0), "R6 read byte 0", rdata, tx_data(e0));
    run(2'd2, 7'h0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(rdata == tx_data(e0 + 1), "R6 read byte 1", rdata, tx_data(e0 + 1));
    run(2'd2, 7'h0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk(rdata == tx_data(e0 + 2), "R6 read byte 2", rdata, tx_data(e0 + 2));
    chk(mack_cnt - m0 == 2, "R6 ACKs", mack_cnt - m0, 2);
    chk(mnack_cnt - n0 == 1, "R6 NACK on last", mnack_cnt - n0, 1);
    chk(stops - p0 == 1 && starts - s0 == 1, "R9 read events", stops - p0, 1);

    // address polling succeeds
    cfg_timeout = 16'd50; nack_left = 3; s0 = starts; p0 = stops;
    run(2'd0, 7'h22, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(starts - s0 == 4, "R3 retries until ACK", starts - s0, 4);
    chk(!err_tmo && stops == p0, "R3 no error no stop", err_tmo, 0);
    run(2'd3, 7'h0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(stops - p0 == 1, "R3 stop command", stops - p0, 1);

    // timeout
    cfg_timeout = 16'd25; nack_left = 1000; s0 = starts; p0 = stops;
    run(2'd0, 7'h22, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(starts - s0 == 3, "R4 attempts before timeout", starts - s0, 3);
    chk(err_tmo, "R4 timeout flag", err_tmo, 1);
    chk(stops - p0 == 1, "R4 STOP on timeout", stops - p0, 1);
    nack_left = 0;
    run(2'd0, 7'h50, 1'b0, 8'h00, 1'b0, 1'b0);
    run(2'd3, 7'h0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(err_tmo, "R10 flag sticky", err_tmo, 1);
    clear_errs();
    chk(!err_tmo, "R10 flag cleared", err_tmo, 0);

    // timeout of zero
    cfg_timeout = 16'd0; nack_left = 1; s0 = starts;
    run(2'd0, 7'h33, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(starts - s0 == 1, "R4 zero timeout single try", starts - s0, 1);
    chk(err_tmo, "R4 zero timeout flag", err_tmo, 1);
    clear_errs();
    nack_left = 0;

    // data NACK
    cfg_timeout = 16'd50; p0 = stops;
    run(2'd0, 7'h10, 1'b0, 8'h00, 1'b0, 1'b0);
    wnack = 1'b1;
    run(2'd1, 7'h0, 1'b0, 8'h77, 1'b0, 1'b0);
    chk(err_dnack, "R7 data NACK flag", err_dnack, 1);
    chk(stops - p0 == 1 && !scl_oe, "R7 STOP on data NACK", stops - p0, 1);
    wnack = 1'b0;
    clear_errs();

    // bus error in address phase
    @(negedge clk); jam = 1'b1;
    run(2'd0, 7'h7F, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(err_bus, "R5 bus error flag", err_bus, 1);
    chk(!err_tmo, "R5 no timeout flag", err_tmo, 0);
    @(negedge clk); jam = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !scl_oe && !sda_oe, "R5 bus released", {busy, scl_oe, sda_oe}, 0);
    clear_errs();

    // random transfers
    for (int i = 0; i < 6; i++) begin
      cfg_div = 8'($urandom_range(0, 5));
      cfg_presc = 2'($urandom_range(0, 1));
      ra = 7'($urandom);
      rb = 8'($urandom);
      if (i == 0) rb = 8'h00;
      if (i == 1) rb = 8'hFF;
      s0 = starts; p0 = stops; w0 = wr_cnt;
      run(2'd0, ra, 1'b0, 8'h00, 1'b0, 1'b0);
      run(2'd1, 7'h0, 1'b0, rb, 1'b0, 1'b0);
      chk(last_wr == rb && wr_cnt - w0 == 1, "R2 random write", last_wr, rb);
      chk(meas_per == exp_period(cfg_div, cfg_presc), "R1 random period",
          meas_per, exp_period(cfg_div, cfg_presc));
      e0 = rd_idx;
      run(2'd0, ra, 1'b1, 8'h00, 1'b0, 1'b0);
      chk(last_addr == {ra, 1'b1}, "R2 random read address", last_addr, {ra, 1'b1});
      run(2'd2, 7'h0, 1'b0, 8'h00, 1'b0, 1'b0);
      chk(rdata == tx_data(e0), "R6 random read 0", rdata, tx_data(e0));
      run(2'd2, 7'h0, 1'b0, 8'h00, 1'b1, 1'b1);
      chk(rdata == tx_data(e0 + 1), "R6 random read 1", rdata, tx_data(e0 + 1));
      chk(starts - s0 == 2, "R9 random START count", starts - s0, 2);
      chk(stops - p0 == 1, "R9 random STOP count", stops - p0, 1);
      chk(!err_tmo && !err_bus && !err_dnack, "R10 no spurious flags",
          {err_tmo, err_bus, err_dnack}, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule